// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block is the register front end of a security coprocessor that takes its commands through a shared command/response buffer. Software reaches it over a simple register bus. Each access carries a byte address, a write strobe, an access size of 1 to 4 bytes and write data. Reads return data combinationally. The block tracks which locality owns the interface, the idle/ready state of the coprocessor, and the start and cancel doorbells. It also presents a fixed capability word and the descriptors of the command and response buffers.

The address space is split into 4 KiB pages, and the page number of a write is the locality of its writer. Software first claims the interface through the locality-control register. It then rings the start doorbell from the page that matches the owning locality. The block then emits a one-cycle command-start pulse to the backend engine. The backend reports the end of the command with a completion strobe and an error flag. Completion clears the doorbell, and an error also latches a sticky fatal status. The buffer memory and the engine lie outside this block.

Top module: `cmdbuf_ctrl`

## Requirements
- R1: After reset the register words read as follows. Locality state (offset 0x000) is 0x80, with bit7 meaning register-valid, plus bit0 as defined in R4. Locality status (0x00C) is 0. Control status (0x044) is 0x2, with bit1 the idle flag and bit0 the fatal flag. Start (0x04C) is 0. The capability word (0x030) is 0x00025811.
- R2: After reset the command size (0x058) and response size (0x064) read BUF_SIZE = 4096 - BUF_OFF, which is 0xF80 by default. The command address (0x05C) and response address (0x068) read BASE_ADDR + BUF_OFF, which is 0xFED40080 by default.
- R3: A read returns the 32-bit word at the aligned offset (address bits [11:2]), shifted right by 8 times address bits [1:0]. The read size is not used, and the page bits do not select the register.
- R4: Bit0 of the locality-state word reads as the inverse of the established input.
- R5: The locality-control register (0x008) acts only on exact values. The value 1 sets locality-assigned (state bit1) and granted (status bit0) and clears seized (status bit1). The value 2 clears assigned and granted. Every other value is ignored, including 4, 8 and 3. The active-locality field (state bits [4:2]) is always 0.
- R6: A write to the control-request register (0x040) acts only on exact values. The value 1 clears the idle flag, the value 2 sets it, and every other value is ignored.
- R7: A write of 1 to the start register is accepted only when the start bit is clear and the writer's page number equals the active locality. The active locality is 0xFF while unassigned, and the active-locality field otherwise. An accepted write sets the start bit and raises cmd_start_o for exactly one cycle, in the cycle after the write.
- R8: A start write made while the start bit is set produces no pulse and changes nothing.
- R9: A write of exactly 1 to the cancel register (0x048) raises cmd_cancel_o for one cycle only if the start bit is set at the time of the write. Otherwise the write is ignored.
- R10: A completion strobe while the start bit is set clears the start bit. If the error flag is also high, the fatal flag is set, and it stays set until reset. A completion strobe while the start bit is clear is ignored.
- R11: Before decoding, the write value is masked to the access size. Commands decode only at their exact byte offset, so a misaligned write does nothing. Writes to read-only registers are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits above 11 give the writer's locality |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 3 | Access size in bytes (1 to 4) |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data for bus_addr |
| established_i | input | 1 | Backend "established" status |
| done_i | input | 1 | Backend completion strobe |
| done_err_i | input | 1 | Error flag qualifying done_i |
| cmd_start_o | output | 1 | One-cycle command-start pulse |
| cmd_cancel_o | output | 1 | One-cycle cancel pulse |

## Verification
The hardest states to reach are the rejections that depend on combined conditions. One is a start write from the right page while the interface is unowned. Another is a start write from a non-zero page while locality 0 owns the interface. A third is a cancel or completion that arrives when no command is in flight. The stimulus reaches each of these through an ordered sequence. It claims and releases locality with exact and non-exact values, and rings the doorbell from several pages and with masked and misaligned writes. It then drives completions with and without the error flag, before and after a command is in flight, and checks the pulses and the sticky fatal flag at the ports.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int PAGE_BITS = 12;
    localparam int LOC_W     = 8;

    typedef logic [PAGE_BITS-1:0] off_t;
    typedef logic [LOC_W-1:0]     loc_t;

    localparam off_t OFF_LOC_STATE   = 12'h000;
    localparam off_t OFF_LOC_CTRL    = 12'h008;
    localparam off_t OFF_LOC_STS     = 12'h00C;
    localparam off_t OFF_INTF_ID     = 12'h030;
    localparam off_t OFF_CTRL_REQ    = 12'h040;
    localparam off_t OFF_CTRL_STS    = 12'h044;
    localparam off_t OFF_CTRL_CANCEL = 12'h048;
    localparam off_t OFF_CTRL_START  = 12'h04C;
    localparam off_t OFF_CMD_SIZE    = 12'h058;
    localparam off_t OFF_CMD_ADDR    = 12'h05C;
    localparam off_t OFF_RSP_SIZE    = 12'h064;
    localparam off_t OFF_RSP_ADDR    = 12'h068;

    localparam loc_t NO_LOC = 8'hFF;
    localparam logic [2:0] ACTIVE_FIELD = 3'd0;

    localparam logic [31:0] V_LOC_REQUEST   = 32'h1;
    localparam logic [31:0] V_LOC_RELEASE   = 32'h2;
    localparam logic [31:0] V_REQ_READY     = 32'h1;
    localparam logic [31:0] V_REQ_IDLE      = 32'h2;
    localparam logic [31:0] V_DOORBELL      = 32'h1;

    typedef struct packed {
        logic loc_request;
        logic loc_release;
        logic go_ready;
        logic go_idle;
        logic start_req;
        logic cancel_req;
    } wcmd_t;

    typedef struct packed {
        logic       assigned;
        logic       granted;
        logic [2:0] active;
    } loc_view_t;

    typedef struct packed {
        logic idle;
        logic fatal;
        logic busy;
    } exec_view_t;

    function automatic logic [31:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd3:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] intf_id_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = 4'd1;   // interface type: buffer interface active
        w[7:4]   = 4'd1;   // interface version
        w[8]     = 1'b0;   // only locality 0 supported
        w[9]     = 1'b0;   // no idle bypass
        w[12:11] = 2'b11;  // 64-byte transfers
        w[13]    = 1'b0;   // no FIFO interface
        w[14]    = 1'b1;   // buffer interface supported
        w[18:17] = 2'b01;  // selector: buffer interface
        w[31:24] = 8'd0;   // revision
        return w;
    endfunction

endpackage

// File: rtl/cmdbuf_wdec.sv
module cmdbuf_wdec
    import cmdbuf_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [2:0]        size,
    input  logic [31:0]       wdata,
    output wcmd_t             cmd,
    output loc_t              wr_loc
);
    localparam int HI_W = ADDR_W - PAGE_BITS;

    logic [31:0] val;
    off_t        off;
    logic [HI_W-1:0] page;

    always_comb begin
        val    = wdata & size_mask(size);
        off    = addr[PAGE_BITS-1:0];
        page   = addr[ADDR_W-1:PAGE_BITS];
        wr_loc = loc_t'(page);
        cmd    = '0;
        if (wr) begin
            cmd.loc_request = (off == OFF_LOC_CTRL)    && (val == V_LOC_REQUEST);
            cmd.loc_release = (off == OFF_LOC_CTRL)    && (val == V_LOC_RELEASE);
            cmd.go_ready    = (off == OFF_CTRL_REQ)    && (val == V_REQ_READY);
            cmd.go_idle     = (off == OFF_CTRL_REQ)    && (val == V_REQ_IDLE);
            cmd.start_req   = (off == OFF_CTRL_START)  && (val == V_DOORBELL);
            cmd.cancel_req  = (off == OFF_CTRL_CANCEL) && (val == V_DOORBELL);
        end
    end
endmodule

// File: rtl/cmdbuf_loc.sv
module cmdbuf_loc
    import cmdbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wcmd_t     cmd,
    output loc_view_t view,
    output loc_t      active_loc
);
    logic assigned_q;
    logic granted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            assigned_q <= 1'b0;
            granted_q  <= 1'b0;
        end else if (cmd.loc_request) begin
            assigned_q <= 1'b1;
            granted_q  <= 1'b1;
        end else if (cmd.loc_release) begin
            assigned_q <= 1'b0;
            granted_q  <= 1'b0;
        end
    end

    always_comb begin
        view.assigned = assigned_q;
        view.granted  = granted_q;
        view.active   = ACTIVE_FIELD;
        active_loc    = assigned_q ? loc_t'(ACTIVE_FIELD) : NO_LOC;
    end
endmodule

// File: rtl/cmdbuf_exec.sv
module cmdbuf_exec
    import cmdbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wcmd_t      cmd,
    input  logic       loc_match,
    input  logic       done_i,
    input  logic       done_err_i,
    output exec_view_t view,
    output logic       start_p,
    output logic       cancel_p
);
    logic idle_q, fatal_q, busy_q;
    logic start_ok, finish;

    always_comb begin
        start_ok = cmd.start_req && !busy_q && loc_match;
        finish   = done_i && busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q   <= 1'b1;
            fatal_q  <= 1'b0;
            busy_q   <= 1'b0;
            start_p  <= 1'b0;
            cancel_p <= 1'b0;
        end else begin
            start_p  <= start_ok;
            cancel_p <= cmd.cancel_req && busy_q;
            if (cmd.go_ready)
                idle_q <= 1'b0;
            else if (cmd.go_idle)
                idle_q <= 1'b1;
            if (start_ok)
                busy_q <= 1'b1;
            else if (finish)
                busy_q <= 1'b0;
            if (finish && done_err_i)
                fatal_q <= 1'b1;
        end
    end

    always_comb begin
        view.idle  = idle_q;
        view.fatal = fatal_q;
        view.busy  = busy_q;
    end
endmodule

// File: rtl/cmdbuf_rdmux.sv
module cmdbuf_rdmux
    import cmdbuf_pkg::*;
#(
    parameter logic [31:0] BUF_SIZE_W = 32'h0000_0F80,
    parameter logic [31:0] BUF_ADDR_W = 32'hFED4_0080
) (
    input  off_t       off,
    input  loc_view_t  loc,
    input  exec_view_t ex,
    input  logic       established_i,
    output logic [31:0] rdata
);
    logic [31:0] word;
    off_t        aligned;

    always_comb begin
        aligned = {off[PAGE_BITS-1:2], 2'b00};
        word    = '0;
        case (aligned)
            OFF_LOC_STATE: begin
                word[0]   = ~established_i;
                word[1]   = loc.assigned;
                word[4:2] = loc.active;
                word[7]   = 1'b1;
            end
            OFF_LOC_STS: begin
                word[0] = loc.granted;
                word[1] = 1'b0;
            end
            OFF_INTF_ID:    word = intf_id_word();
            OFF_CTRL_STS: begin
                word[0] = ex.fatal;
                word[1] = ex.idle;
            end
            OFF_CTRL_START: word[0] = ex.busy;
            OFF_CMD_SIZE,
            OFF_RSP_SIZE:   word = BUF_SIZE_W;
            OFF_CMD_ADDR,
            OFF_RSP_ADDR:   word = BUF_ADDR_W;
            default:        word = '0;
        endcase
        rdata = word >> {off[1:0], 3'b000};
    end
endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl
    import cmdbuf_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
    parameter int          BUF_OFF   = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              established_i,
    input  logic              done_i,
    input  logic              done_err_i,
    output logic              cmd_start_o,
    output logic              cmd_cancel_o
);
    localparam int          PAGE_BYTES = 1 << PAGE_BITS;
    localparam logic [31:0] BUF_SIZE_W = 32'(PAGE_BYTES - BUF_OFF);
    localparam logic [31:0] BUF_ADDR_W = BASE_ADDR + 32'(BUF_OFF);

    wcmd_t      wcmd;
    loc_t       wr_loc;
    loc_t       active_loc;
    loc_view_t  loc_view;
    exec_view_t ex_view;
    logic       loc_match;
    logic       busy;
    logic       fatal;
    logic       loc_assigned;

    cmdbuf_wdec #(.ADDR_W(ADDR_W)) u_wdec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .size   (bus_size),
        .wdata  (bus_wdata),
        .cmd    (wcmd),
        .wr_loc (wr_loc)
    );

    cmdbuf_loc u_loc (
        .clk        (clk),
        .rst        (rst),
        .cmd        (wcmd),
        .view       (loc_view),
        .active_loc (active_loc)
    );

    assign loc_match = (wr_loc == active_loc);

    cmdbuf_exec u_exec (
        .clk        (clk),
        .rst        (rst),
        .cmd        (wcmd),
        .loc_match  (loc_match),
        .done_i     (done_i),
        .done_err_i (done_err_i),
        .view       (ex_view),
        .start_p    (cmd_start_o),
        .cancel_p   (cmd_cancel_o)
    );

    cmdbuf_rdmux #(
        .BUF_SIZE_W (BUF_SIZE_W),
        .BUF_ADDR_W (BUF_ADDR_W)
    ) u_rdmux (
        .off           (bus_addr[PAGE_BITS-1:0]),
        .loc           (loc_view),
        .ex            (ex_view),
        .established_i (established_i),
        .rdata         (bus_rdata)
    );

    assign busy         = ex_view.busy;
    assign fatal        = ex_view.fatal;
    assign loc_assigned = loc_view.assigned;
endmodule

// File: rtl/cmdbuf_ctrl_chk.sv
module cmdbuf_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start_o,
    input logic cancel_o,
    input logic done_i,
    input logic done_err_i,
    input logic busy,
    input logic fatal,
    input logic assigned
);
    p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    p_start_needs_owner_r7: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(assigned));

    p_start_sets_busy_r7: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(!busy));

    p_cancel_in_flight_r9: assert property (@(posedge clk) disable iff (rst)
        cancel_o |-> $past(busy));

    p_cancel_single_r9: assert property (@(posedge clk) disable iff (rst)
        cancel_o |=> !cancel_o);

    p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (done_i && busy) |=> !busy);

    p_err_fatal_r10: assert property (@(posedge clk) disable iff (rst)
        (done_i && busy && done_err_i) |=> fatal);

    p_fatal_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal);
endmodule

bind cmdbuf_ctrl cmdbuf_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_o    (cmd_start_o),
    .cancel_o   (cmd_cancel_o),
    .done_i     (done_i),
    .done_err_i (done_err_i),
    .busy       (busy),
    .fatal      (fatal),
    .assigned   (loc_assigned)
);

// File: tb/tb_cmdbuf_ctrl.sv
module tb_cmdbuf_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        established_i = 1'b1;
    logic        done_i = 1'b0;
    logic        done_err_i = 1'b0;
    logic        cmd_start_o;
    logic        cmd_cancel_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cmdbuf_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .established_i (established_i),
        .done_i        (done_i),
        .done_err_i    (done_err_i),
        .cmd_start_o   (cmd_start_o),
        .cmd_cancel_o  (cmd_cancel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [31:0] d, input logic [2:0] sz);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = sz;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done(input logic err);
        @(negedge clk);
        done_i     = 1'b1;
        done_err_i = err;
        @(negedge clk);
        done_i     = 1'b0;
        done_err_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(15'h000, d); chk("R1 loc state", d, 32'h80);
        rd(15'h00C, d); chk("R1 loc status", d, 32'h0);
        rd(15'h044, d); chk("R1 ctrl status", d, 32'h2);
        rd(15'h04C, d); chk("R1 start", d, 32'h0);
        rd(15'h030, d); chk("R1 capability", d, 32'h00025811);
        rd(15'h058, d); chk("R2 cmd size", d, 32'hF80);
        rd(15'h064, d); chk("R2 rsp size", d, 32'hF80);
        rd(15'h05C, d); chk("R2 cmd addr", d, 32'hFED40080);
        rd(15'h068, d); chk("R2 rsp addr", d, 32'hFED40080);
        established_i = 1'b0;
        rd(15'h000, d); chk("R4 not established", d, 32'h81);
        established_i = 1'b1;
        rd(15'h000, d); chk("R4 established", d, 32'h80);
    endtask

    task automatic t_read_shift;
        logic [31:0] d;
        rd(15'h031, d); chk("R3 offset 1", d, 32'h000258);
        rd(15'h032, d); chk("R3 offset 2", d, 32'h0002);
        rd(15'h033, d); chk("R3 offset 3", d, 32'h00);
        rd(15'h1030, d); chk("R3 page ignored on read", d, 32'h00025811);
    endtask

    task automatic t_start_unowned;
        logic [31:0] d;
        wr(15'h04C, 32'h1, 3'd4);
        chk("R7 no pulse while unowned", {31'b0, cmd_start_o}, 32'h0);
        rd(15'h04C, d); chk("R7 start stays clear while unowned", d, 32'h0);
    endtask

    task automatic t_locality;
        logic [31:0] d;
        wr(15'h008, 32'h4, 3'd4);
        rd(15'h00C, d); chk("R5 value 4 ignored", d, 32'h0);
        wr(15'h008, 32'h8, 3'd4);
        rd(15'h000, d); chk("R5 value 8 ignored", d, 32'h80);
        wr(15'h008, 32'h3, 3'd4);
        rd(15'h000, d); chk("R5 value 3 ignored", d, 32'h80);
        wr(15'h008, 32'h1, 3'd4);
        rd(15'h000, d); chk("R5 request assigns", d, 32'h82);
        rd(15'h00C, d); chk("R5 request grants", d, 32'h1);
        wr(15'h008, 32'h2, 3'd4);
        rd(15'h000, d); chk("R5 release unassigns", d, 32'h80);
        rd(15'h00C, d); chk("R5 release ungrants", d, 32'h0);
        wr(15'h008, 32'h1, 3'd4);
        rd(15'h00C, d); chk("R5 request again", d, 32'h1);
    endtask

    task automatic t_start_wrong_page;
        logic [31:0] d;
        wr(15'h104C, 32'h1, 3'd4);
        chk("R7 page 1 rejected", {31'b0, cmd_start_o}, 32'h0);
        rd(15'h04C, d); chk("R7 page 1 leaves start clear", d, 32'h0);
    endtask

    task automatic t_start_ok;
        logic [31:0] d;
        wr(15'h04C, 32'h101, 3'd1);
        chk("R7 R11 masked start pulses", {31'b0, cmd_start_o}, 32'h1);
        rd(15'h04C, d); chk("R7 start bit set", d, 32'h1);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", {31'b0, cmd_start_o}, 32'h0);
        wr(15'h04C, 32'h1, 3'd4);
        chk("R8 restart gives no pulse", {31'b0, cmd_start_o}, 32'h0);
        rd(15'h04C, d); chk("R8 start bit unchanged", d, 32'h1);
    endtask

    task automatic t_cancel_busy;
        wr(15'h048, 32'h3, 3'd4);
        chk("R9 cancel value 3 ignored", {31'b0, cmd_cancel_o}, 32'h0);
        wr(15'h048, 32'h1, 3'd4);
        chk("R9 cancel while busy pulses", {31'b0, cmd_cancel_o}, 32'h1);
        @(negedge clk);
        chk("R9 cancel pulse one cycle", {31'b0, cmd_cancel_o}, 32'h0);
    endtask

    task automatic t_complete_ok;
        logic [31:0] d;
        done(1'b0);
        rd(15'h04C, d); chk("R10 completion clears start", d, 32'h0);
        rd(15'h044, d); chk("R10 clean completion keeps fatal clear", d, 32'h2);
        wr(15'h048, 32'h1, 3'd4);
        chk("R9 cancel while idle ignored", {31'b0, cmd_cancel_o}, 32'h0);
        done(1'b1);
        rd(15'h044, d); chk("R10 stray completion ignored", d, 32'h2);
    endtask

    task automatic t_complete_err;
        logic [31:0] d;
        wr(15'h04C, 32'h1, 3'd4);
        chk("R7 second start pulses", {31'b0, cmd_start_o}, 32'h1);
        done(1'b1);
        rd(15'h044, d); chk("R10 error sets fatal", d, 32'h3);
        rd(15'h04C, d); chk("R10 error completion clears start", d, 32'h0);
        repeat (3) @(negedge clk);
        rd(15'h044, d); chk("R10 fatal is sticky", d, 32'h3);
    endtask

    task automatic t_idle;
        logic [31:0] d;
        wr(15'h040, 32'h1, 3'd4);
        rd(15'h044, d); chk("R6 ready clears idle", d, 32'h1);
        wr(15'h040, 32'h3, 3'd4);
        rd(15'h044, d); chk("R6 value 3 ignored", d, 32'h1);
        wr(15'h040, 32'h2, 3'd2);
        rd(15'h044, d); chk("R6 go idle sets idle", d, 32'h3);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(15'h030, 32'h0, 3'd4);
        rd(15'h030, d); chk("R11 capability write ignored", d, 32'h00025811);
        wr(15'h058, 32'h1234, 3'd4);
        rd(15'h058, d); chk("R11 size write ignored", d, 32'hF80);
        rd(15'h020, d); chk("R11 unmapped reads zero", d, 32'h0);
        wr(15'h04D, 32'h1, 3'd1);
        chk("R11 misaligned start ignored", {31'b0, cmd_start_o}, 32'h0);
        rd(15'h04C, d); chk("R11 misaligned leaves start clear", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_shift();
        t_start_unowned();
        t_locality();
        t_start_wrong_page();
        t_start_ok();
        t_cancel_busy();
        t_complete_ok();
        t_complete_err();
        t_idle();
        t_readonly();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule